// File: doc/BRIEF.md
# NAND Flash Register Bridge

This block sits on a simple host bus as a single 32-bit register and turns each host access into raw NAND flash pin activity. Every write holds a 3-bit cycle selector, a chip-enable request and one data byte. Depending on the selector, the bridge runs one command-latch, address-latch or data-write strobe on the flash pins. It can also arm itself for reading, or only update chip enable.

Once the bridge is armed, each host read of the register runs one read strobe on the flash. The byte the flash presents at the end of that strobe comes back to the host. Every read result also carries a busy flag, taken from the flash ready/busy line after synchronisation.

The host issues one access at a time as a single-cycle strobe. It then waits for the one-cycle acknowledge, which arrives only when the pin sequence for that access has finished. The setup, strobe-low and hold lengths are counted in clocks and set by parameters.

Top module: `nand_regbridge`

## Requirements
- R1: While reset is held and after it is released, with no access issued, nand_ce_n is 1, nand_cle and nand_ale are 0, nand_we_n and nand_re_n are 1, nand_dq_oe is 0 (data bus released) and host_ack is 0.
- R2: Every accepted write copies host_wdata[31] to the chip-enable state: nand_ce_n equals the inverse of that bit from the clock after the write, for all eight selector values.
- R3: A write with host_wdata[30:28] equal to 0 runs one write strobe with nand_cle high and nand_ale low. Selector 1 does the same with nand_ale high and nand_cle low. Selector 3 does the same with both low. nand_cle and nand_ale are never high together.
- R4: For selectors 0, 1 and 3, nand_dq_o carries host_wdata[23:16] with nand_dq_oe high. nand_we_n is low for exactly PULSE_CYC clocks. Data, nand_cle and nand_ale are driven and stable for SETUP_CYC clocks before the falling strobe edge and for HOLD_CYC clocks after its rising edge.
- R5: For an access that runs a flash strobe, host_ack pulses for one clock, SETUP_CYC+PULSE_CYC+HOLD_CYC clocks after the clock that accepted the access. Any other access is acknowledged on the clock after it is accepted.
- R6: A write with selector 2 arms reading. Each later read runs one nand_re_n pulse of PULSE_CYC clocks, with the data bus released. It returns the byte sampled from nand_dq_i at the end of that pulse in host_rdata[23:16].
- R7: Back-to-back selector-3 writes each produce their own separate write strobe, each carrying its own byte.
- R8: Writes with selectors 4 to 7 cause no flash strobe and leave the read arming unchanged; they only update chip enable.
- R9: host_rdata[15] is 1 while nand_rb_n is 0, after a two-flop synchroniser. host_rdata bits 31:24 and 14:0 are always 0.
- R10: Selectors 0, 1 and 3 disarm reading. A read while disarmed runs no flash strobe and returns the last captured byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Single-cycle register write strobe |
| host_rd | input | 1 | Single-cycle register read strobe |
| host_wdata | input | 32 | Write word: [31] chip enable, [30:28] selector, [23:16] byte |
| host_rdata | output | 32 | Read word: [23:16] captured byte, [15] busy |
| host_ack | output | 1 | One-cycle completion pulse for the current access |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus out value |
| nand_dq_oe | output | 1 | Data bus drive enable; 0 means released |
| nand_dq_i | input | 8 | Data bus in value |
| nand_rb_n | input | 1 | Flash ready/busy, low while busy |

## Verification
The assertions assume the host raises exactly one of host_wr or host_rd for a single clock, and only once the previous access has been acknowledged. They also assume nand_dq_i holds steady across a read strobe; nand_rb_n may change at any time because it is synchronised. The bench meets these assumptions in two ways. It issues each access from a task that drops the strobe after one clock and waits for host_ack before returning. It changes nand_dq_i and nand_rb_n only between accesses.

// File: rtl/nrb_pkg.sv
package nrb_pkg;

   localparam int WORD_W   = 32;
   localparam int BYTE_W   = 8;
   localparam int CE_BIT   = 31;
   localparam int SEL_LSB  = 28;
   localparam int SEL_W    = 3;
   localparam int BYTE_LSB = 16;
   localparam int BUSY_BIT = 15;

   typedef logic [SEL_W-1:0] sel_t;
   localparam sel_t SEL_CMD  = 3'd0;
   localparam sel_t SEL_ADDR = 3'd1;
   localparam sel_t SEL_ARM  = 3'd2;
   localparam sel_t SEL_DWR  = 3'd3;

   typedef enum logic [1:0] {CYC_CMD, CYC_ADDR, CYC_WR, CYC_RD} cyc_e;
   typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;

endpackage

// File: rtl/nrb_sync.sv
module nrb_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("nrb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr[0] <= RESET_VAL;
      else        sr[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr[i] <= RESET_VAL;
         else        sr[i] <= sr[i-1];
      end
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/nrb_seq.sv
module nrb_seq
   import nrb_pkg::*;
#(
   parameter int SETUP_CYC = 2,
   parameter int PULSE_CYC = 3,
   parameter int HOLD_CYC  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  cyc_e              kind,
   input  logic [BYTE_W-1:0] wbyte,
   input  logic [BYTE_W-1:0] dq_i,
   output logic              idle,
   output logic              done,
   output logic              cle,
   output logic              ale,
   output logic              we_n,
   output logic              re_n,
   output logic [BYTE_W-1:0] dq_o,
   output logic              dq_oe,
   output logic [BYTE_W-1:0] rbyte
);
   localparam int MAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
   localparam int MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
   localparam int CW    = (MAX_C > 1) ? $clog2(MAX_C) : 1;

   if (SETUP_CYC < 1) begin : g_bad_setup
      $error("nrb_seq: SETUP_CYC must be at least 1");
   end
   if (PULSE_CYC < 1) begin : g_bad_pulse
      $error("nrb_seq: PULSE_CYC must be at least 1");
   end
   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("nrb_seq: HOLD_CYC must be at least 1");
   end

   phase_e            ph;
   logic [CW-1:0]     cnt;
   cyc_e              kind_q;
   logic [BYTE_W-1:0] byte_q;
   logic              last;

   assign last = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= PH_IDLE;
         cnt    <= '0;
         kind_q <= CYC_CMD;
         byte_q <= '0;
         rbyte  <= '0;
      end else begin
         unique case (ph)
            PH_IDLE: begin
               if (start) begin
                  ph     <= PH_SETUP;
                  cnt    <= CW'(SETUP_CYC - 1);
                  kind_q <= kind;
                  byte_q <= wbyte;
               end
            end
            PH_SETUP: begin
               if (last) begin
                  ph  <= PH_STROBE;
                  cnt <= CW'(PULSE_CYC - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_STROBE: begin
               if (last) begin
                  ph  <= PH_HOLD;
                  cnt <= CW'(HOLD_CYC - 1);
                  if (kind_q == CYC_RD) rbyte <= dq_i;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_HOLD: begin
               if (last) ph  <= PH_IDLE;
               else      cnt <= cnt - 1'b1;
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   logic active, strobe, is_rd;
   assign active = (ph != PH_IDLE);
   assign strobe = (ph == PH_STROBE);
   assign is_rd  = (kind_q == CYC_RD);

   assign idle  = !active;
   assign done  = (ph == PH_HOLD) && last;
   assign cle   = active && (kind_q == CYC_CMD);
   assign ale   = active && (kind_q == CYC_ADDR);
   assign we_n  = !(strobe && !is_rd);
   assign re_n  = !(strobe && is_rd);
   assign dq_oe = active && !is_rd;
   assign dq_o  = dq_oe ? byte_q : '0;
endmodule

// File: rtl/nand_regbridge.sv
module nand_regbridge
   import nrb_pkg::*;
#(
   parameter int SETUP_CYC   = 2,
   parameter int PULSE_CYC   = 3,
   parameter int HOLD_CYC    = 1,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_wr,
   input  logic        host_rd,
   input  logic [31:0] host_wdata,
   output logic [31:0] host_rdata,
   output logic        host_ack,
   output logic        nand_ce_n,
   output logic        nand_cle,
   output logic        nand_ale,
   output logic        nand_we_n,
   output logic        nand_re_n,
   output logic [7:0]  nand_dq_o,
   output logic        nand_dq_oe,
   input  logic [7:0]  nand_dq_i,
   input  logic        nand_rb_n
);
   logic              seq_idle, seq_done, seq_start;
   logic              wr_go, rd_go, flash_sel, imm_ack;
   logic              ce_q, armed_q, ack_q, rb_sync;
   sel_t              sel;
   cyc_e              kind;
   logic [BYTE_W-1:0] wbyte, rbyte;
   logic              wdata_unused;

   assign sel   = host_wdata[SEL_LSB +: SEL_W];
   assign wbyte = host_wdata[BYTE_LSB +: BYTE_W];
   assign wdata_unused = ^{host_wdata[27:24], host_wdata[15:0]};

   assign wr_go     = host_wr && seq_idle;
   assign rd_go     = host_rd && !host_wr && seq_idle;
   assign flash_sel = (sel == SEL_CMD) || (sel == SEL_ADDR) || (sel == SEL_DWR);
   assign seq_start = (wr_go && flash_sel) || (rd_go && armed_q);
   assign imm_ack   = (wr_go && !flash_sel) || (rd_go && !armed_q);

   always_comb begin
      if (!wr_go)                kind = CYC_RD;
      else if (sel == SEL_CMD)   kind = CYC_CMD;
      else if (sel == SEL_ADDR)  kind = CYC_ADDR;
      else                       kind = CYC_WR;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_q    <= 1'b0;
         armed_q <= 1'b0;
         ack_q   <= 1'b0;
      end else begin
         ack_q <= imm_ack || seq_done;
         if (wr_go) begin
            ce_q <= host_wdata[CE_BIT];
            if (sel == SEL_ARM)  armed_q <= 1'b1;
            else if (flash_sel)  armed_q <= 1'b0;
         end
      end
   end

   nrb_seq #(
      .SETUP_CYC (SETUP_CYC),
      .PULSE_CYC (PULSE_CYC),
      .HOLD_CYC  (HOLD_CYC)
   ) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (seq_start),
      .kind  (kind),
      .wbyte (wbyte),
      .dq_i  (nand_dq_i),
      .idle  (seq_idle),
      .done  (seq_done),
      .cle   (nand_cle),
      .ale   (nand_ale),
      .we_n  (nand_we_n),
      .re_n  (nand_re_n),
      .dq_o  (nand_dq_o),
      .dq_oe (nand_dq_oe),
      .rbyte (rbyte)
   );

   nrb_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_rb_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (nand_rb_n),
      .q     (rb_sync)
   );

   always_comb begin
      host_rdata = '0;
      host_rdata[BYTE_LSB +: BYTE_W] = rbyte;
      host_rdata[BUSY_BIT] = !rb_sync;
   end

   assign host_ack  = ack_q;
   assign nand_ce_n = !ce_q;
endmodule

// File: rtl/nrb_checker.sv
module nrb_checker #(
   parameter int SYNC_STAGES = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       host_wr,
   input logic       wr_ce,
   input logic       seq_idle,
   input logic       busy_flag,
   input logic       nand_ce_n,
   input logic       nand_cle,
   input logic       nand_ale,
   input logic       nand_we_n,
   input logic       nand_re_n,
   input logic [7:0] nand_dq_o,
   input logic       nand_dq_oe,
   input logic       nand_rb_n
);
   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           age <= 2'd0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale)); // R3

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_re_n)); // R6

   AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nand_we_n) |-> nand_dq_oe && $stable(nand_dq_o) && $stable(nand_cle) && $stable(nand_ale)); // R4

   AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nand_we_n) |-> nand_dq_oe && $stable(nand_dq_o) && $stable(nand_cle) && $stable(nand_ale)); // R4

   AST_BUS_FREE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_re_n |-> !nand_dq_oe); // R6

   AST_CE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && seq_idle) |=> (nand_ce_n == !$past(wr_ce))); // R2

   if (SYNC_STAGES == 2) begin : g_busy_chk
      AST_BUSY_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
         (age == 2'd3) |-> (busy_flag == !$past(nand_rb_n, 2))); // R9
   end
endmodule

bind nand_regbridge nrb_checker #(
   .SYNC_STAGES (SYNC_STAGES)
) u_nrb_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_wr    (host_wr),
   .wr_ce      (host_wdata[31]),
   .seq_idle   (seq_idle),
   .busy_flag  (host_rdata[15]),
   .nand_ce_n  (nand_ce_n),
   .nand_cle   (nand_cle),
   .nand_ale   (nand_ale),
   .nand_we_n  (nand_we_n),
   .nand_re_n  (nand_re_n),
   .nand_dq_o  (nand_dq_o),
   .nand_dq_oe (nand_dq_oe),
   .nand_rb_n  (nand_rb_n)
);

// File: tb/nand_regbridge_bench.sv
module nand_regbridge_bench;
   localparam int CLK_P = 10;
   localparam int S = 2;
   localparam int P = 3;
   localparam int H = 2;
   localparam int FLASH_LAT = S + P + H + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        host_ack;
   logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [7:0]  nand_dq_o;
   logic [7:0]  nand_dq_i = '0;
   logic        nand_rb_n = 1'b1;

   int checks = 0;
   int fails  = 0;

   always #(CLK_P/2) clk = ~clk;

   nand_regbridge #(
      .SETUP_CYC (S), .PULSE_CYC (P), .HOLD_CYC (H), .SYNC_STAGES (2)
   ) u_nand_regbridge (
      .clk (clk), .rst_n (rst_n),
      .host_wr (host_wr), .host_rd (host_rd), .host_wdata (host_wdata),
      .host_rdata (host_rdata), .host_ack (host_ack),
      .nand_ce_n (nand_ce_n), .nand_cle (nand_cle), .nand_ale (nand_ale),
      .nand_we_n (nand_we_n), .nand_re_n (nand_re_n),
      .nand_dq_o (nand_dq_o), .nand_dq_oe (nand_dq_oe),
      .nand_dq_i (nand_dq_i), .nand_rb_n (nand_rb_n)
   );

   // pin monitor, sampled at the falling clock edge
   int   we_pulses = 0, re_pulses = 0, we_width = 0, re_width = 0;
   int   we_setup = 0, we_hold = 0, pre_cnt = 0, oe_on_read = 0, both_hi = 0;
   logic cap_cle = 0, cap_ale = 0, setup_stable = 0;
   logic [7:0] cap_dq = '0;
   logic prev_we = 1, prev_re = 1, p_cle = 0, p_ale = 0, p_oe = 0;
   logic [7:0] p_dq = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!nand_we_n) begin
            if (prev_we) begin
               we_pulses++;
               we_setup = pre_cnt;
               cap_cle = nand_cle; cap_ale = nand_ale; cap_dq = nand_dq_o;
               setup_stable = p_oe && (p_cle == nand_cle) && (p_ale == nand_ale) && (p_dq == nand_dq_o);
               we_width = 0; we_hold = 0;
            end
            we_width++;
         end else if (nand_dq_oe) begin
            pre_cnt++; we_hold++;
         end else begin
            pre_cnt = 0;
         end
         if (!nand_re_n) begin
            if (prev_re) begin re_pulses++; re_width = 0; end
            re_width++;
            if (nand_dq_oe) oe_on_read++;
         end
         if (nand_cle && nand_ale) both_hi++;
      end
      prev_we = nand_we_n; prev_re = nand_re_n;
      p_cle = nand_cle; p_ale = nand_ale; p_oe = nand_dq_oe; p_dq = nand_dq_o;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_write(input logic [31:0] w, output int lat);
      host_wr = 1'b1; host_wdata = w;
      @(negedge clk);
      host_wr = 1'b0;
      lat = 1;
      while (!host_ack && lat < 200) begin @(negedge clk); lat++; end
   endtask

   task automatic do_read(output logic [31:0] d, output int lat);
      host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
      lat = 1;
      while (!host_ack && lat < 200) begin @(negedge clk); lat++; end
      d = host_rdata;
   endtask

   function automatic logic [31:0] mk(input bit ce, input int sel, input logic [7:0] b);
      return {ce, 3'(sel), 4'h0, b, 16'h0};
   endfunction

   function automatic logic [31:0] rword(input logic [7:0] b, input bit busy);
      return {8'h00, b, busy, 15'h0};
   endfunction

   task automatic check_idle_pins(input string req);
      check(nand_ce_n === 1'b1, req, "ce_n idle", int'(nand_ce_n), 1);
      check(nand_cle === 1'b0 && nand_ale === 1'b0, req, "cle/ale idle",
            int'({nand_cle, nand_ale}), 0);
      check(nand_we_n === 1'b1 && nand_re_n === 1'b1, req, "strobes idle",
            int'({nand_we_n, nand_re_n}), 3);
      check(nand_dq_oe === 1'b0, req, "bus released", int'(nand_dq_oe), 0);
      check(host_ack === 1'b0, req, "ack idle", int'(host_ack), 0);
   endtask

   initial begin
      #(CLK_P * 150000);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int lat, wb, rb;
      logic [31:0] rd;
      logic [7:0] byt;

      repeat (3) @(negedge clk);
      check_idle_pins("R1");                        // during reset
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_idle_pins("R1");                        // after release

      // sweep: chip-enable value x selector x byte
      for (int ce = 0; ce < 2; ce++) begin
         for (int sel = 0; sel < 8; sel++) begin
            for (int k = 0; k < 3; k++) begin
               byt = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'(sel * 37 + ce * 91 + 5);
               wb = we_pulses; rb = re_pulses;
               do_write(mk(ce[0], sel, byt), lat);
               check(nand_ce_n === !ce[0], "R2", "ce_n after write", int'(nand_ce_n), int'(!ce[0]));
               if (sel == 0 || sel == 1 || sel == 3) begin
                  check(lat == FLASH_LAT, "R5", "flash ack latency", lat, FLASH_LAT);
                  check(we_pulses == wb + 1, "R3", "one WE strobe", we_pulses - wb, 1);
                  check(cap_cle == (sel == 0) && cap_ale == (sel == 1), "R3", "cle/ale",
                        int'({cap_cle, cap_ale}), int'({sel == 0, sel == 1}));
                  check(cap_dq == byt, "R4", "byte on bus", int'(cap_dq), int'(byt));
                  check(we_width == P, "R4", "WE width", we_width, P);
                  check(we_setup == S && setup_stable, "R4", "setup clocks", we_setup, S);
                  check(we_hold == H, "R4", "hold clocks", we_hold, H);
               end else begin
                  check(lat == 1, "R5", "immediate ack latency", lat, 1);
                  check(we_pulses == wb, "R8", "no WE strobe", we_pulses - wb, 0);
               end
               check(re_pulses == rb, "R8", "no RE strobe on write", re_pulses - rb, 0);
            end
         end
      end

      // back-to-back data writes, each with its own byte
      for (int i = 0; i < 6; i++) begin
         byt = 8'(8'h11 * (i + 1));
         wb = we_pulses;
         do_write(mk(1'b1, 3, byt), lat);
         check(we_pulses == wb + 1 && cap_dq == byt, "R7", "burst write byte",
               int'(cap_dq), int'(byt));
      end

      // armed reads
      do_write(mk(1'b1, 2, 8'h00), lat);
      check(lat == 1, "R6", "arm ack latency", lat, 1);
      for (int i = 0; i < 4; i++) begin
         byt = 8'(8'h3C ^ (i * 8'h55));
         nand_dq_i = byt;
         rb = re_pulses; wb = we_pulses;
         do_read(rd, lat);
         check(lat == FLASH_LAT, "R6", "read ack latency", lat, FLASH_LAT);
         check(re_pulses == rb + 1 && we_pulses == wb, "R6", "one RE strobe", re_pulses - rb, 1);
         check(re_width == P, "R6", "RE width", re_width, P);
         check(rd == rword(byt, 1'b0), "R6", "read word", int'(rd), int'(rword(byt, 1'b0)));
      end
      check(oe_on_read == 0, "R6", "bus driven during RE", oe_on_read, 0);

      // selectors 4..7 keep arming
      do_write(mk(1'b1, 6, 8'h00), lat);
      nand_dq_i = 8'h9A;
      rb = re_pulses;
      do_read(rd, lat);
      check(re_pulses == rb + 1 && rd[23:16] == 8'h9A, "R8", "still armed after sel 6",
            int'(rd[23:16]), 8'h9A);

      // address write disarms; read returns last byte without a strobe
      do_write(mk(1'b1, 1, 8'h40), lat);
      nand_dq_i = 8'h77;
      rb = re_pulses;
      do_read(rd, lat);
      check(lat == 1, "R10", "disarmed read latency", lat, 1);
      check(re_pulses == rb, "R10", "no RE when disarmed", re_pulses - rb, 0);
      check(rd == rword(8'h9A, 1'b0), "R10", "last byte kept", int'(rd), int'(rword(8'h9A, 1'b0)));

      // busy flag through synchroniser
      nand_rb_n = 1'b0;
      repeat (3) @(negedge clk);
      do_read(rd, lat);
      check(rd == rword(8'h9A, 1'b1), "R9", "busy set", int'(rd), int'(rword(8'h9A, 1'b1)));
      nand_rb_n = 1'b1;
      repeat (3) @(negedge clk);
      do_read(rd, lat);
      check(rd == rword(8'h9A, 1'b0), "R9", "busy clear", int'(rd), int'(rword(8'h9A, 1'b0)));

      check(both_hi == 0, "R3", "cle and ale together", both_hi, 0);

      do_write(mk(1'b0, 7, 8'h00), lat);
      @(negedge clk);
      check_idle_pins("R1");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule